// File: doc/BRIEF.md
# Initial Program Load Sequencer

This block runs the power-up load step of a processor. An operator selects the boot device with three selector fields: a 3-bit channel field and two 4-bit fields for the control unit and the device. These are joined into an 11-bit device address. A load request first runs the same internal reset sequence that a system reset performs. The block then accepts 24 bytes from a byte stream with a valid/ready handshake and writes them, in arrival order, to addresses 0 to 23 of a byte-addressed memory.

The 24-byte image is an 8-byte initial status word followed by two 8-byte channel command words. A load indicator lights when the request is taken and stays lit until all 24 bytes have been stored. If the device raises an error, or no byte arrives within a timeout window, the load ends as a failure. The block then idles with a failure indicator on and the load indicator still lit.

A restart request is accepted only when the processor reports the manual state. It reads the 8-byte status word from memory address 0 and presents the 24-bit instruction address held in its last three bytes, together with a one-cycle valid pulse. The memory itself lives outside the block: write and read ports are registered, and read data returns one cycle after a read strobe. This suits block RAM.

Top module: `ipl_seq`

## Requirements
- R1: When a load request is accepted, `dev_addr` captures `{sel_chan, sel_cu, sel_dev}`: the channel field in bits 10:8, the control-unit field in bits 7:4 and the device field in bits 3:0. It keeps that value until the next accepted load.
- R2: An accepted load holds `sys_reset_o` high for exactly RST_CYCLES consecutive cycles. During those cycles there is no memory write and `in_ready` is low. `in_ready` rises on the same edge that `sys_reset_o` falls. Memory contents are never altered by the reset.
- R3: A successful load writes exactly IMG_BYTES (24) bytes. The k-th accepted stream byte goes to address k, with one `mem_we` pulse per accepted byte. Addresses at or above 24 are never written, and `in_ready` is low after the 24th byte.
- R4: `load_active` is high from the cycle after the load request until the cycle after the last byte is written. On that cycle `load_ok` rises and `load_active` falls. Any new load clears `load_ok` and `fail_idle`.
- R5: An `in_err` seen while `in_ready` is high ends the load. The erroring beat is not written. One cycle later `fail_idle` is 1 and `load_active` stays 1, with no further writes and `in_ready` low.
- R6: While the load is waiting, TIMEOUT consecutive cycles with `in_ready` high and no valid byte end the load as a failure, with the same outputs as R5.
- R7: `restart_req` with `manual_i`=1 while the block is idle reads addresses 0 to 7 in order. It then pulses `start_valid` for one cycle with `start_pc` = {byte5, byte6, byte7}, which are bits 40–63 of the big-endian status word.
- R8: `restart_req` with `manual_i`=0 is ignored: no `mem_re` and no `start_valid`.
- R9: `load_req` and `restart_req` arriving during a reset or load sequence are ignored. The byte count continues and the reset is not rerun.
- R10: After reset, `load_active`, `load_ok`, `fail_idle`, `sys_reset_o`, `in_ready`, `mem_we`, `mem_re` and `start_valid` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_chan | input | 3 | Channel selector field |
| sel_cu | input | 4 | Control-unit selector field |
| sel_dev | input | 4 | Device selector field |
| load_req | input | 1 | Load request pulse |
| restart_req | input | 1 | Restart request pulse |
| manual_i | input | 1 | Processor is in the manual state |
| in_valid | input | 1 | Stream byte valid |
| in_data | input | 8 | Stream byte |
| in_err | input | 1 | Device error flag |
| in_ready | output | 1 | Stream ready |
| dev_addr | output | 11 | Latched boot device address |
| sys_reset_o | output | 1 | Internal system reset |
| mem_we | output | 1 | Memory write strobe |
| mem_waddr | output | MEM_AW | Memory write address |
| mem_wdata | output | 8 | Memory write byte |
| mem_re | output | 1 | Memory read strobe |
| mem_raddr | output | MEM_AW | Memory read address |
| mem_rdata | input | 8 | Memory read byte, one cycle after `mem_re` |
| load_active | output | 1 | Load indicator |
| load_ok | output | 1 | Load completed |
| fail_idle | output | 1 | Load failed, processor idling |
| start_valid | output | 1 | Restart address valid pulse |
| start_pc | output | 24 | Restart instruction address |

## Verification
`load_active` and `sys_reset_o` are sampled one edge after the request. `in_ready` is due RST_CYCLES edges later. Each accepted byte appears on the write port on the acceptance edge, and `load_ok` follows one edge after the last write. `fail_idle` follows two edges after an error beat, and TIMEOUT+1 edges after `in_ready` rises in the timeout case. The bench samples every one of these results at the falling edge just after the edge on which it is due, and it checks before and after the timeout window. The `start_pc` value is due ten edges after an accepted restart: eight reads plus the memory latency and one capture register. The bench waits for the pulse with a bounded count and compares it against the bytes it wrote.

// File: rtl/ipl_pkg.sv
package ipl_pkg;
  localparam int BYTE_W    = 8;
  localparam int DEVA_W    = 11;
  localparam int SW_BYTES  = 8;
  localparam int IA_BYTES  = 3;
  localparam int IA_W      = IA_BYTES * BYTE_W;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RESET,
    ST_LOAD,
    ST_FAIL,
    ST_FETCH
  } ipl_state_t;
endpackage

// File: rtl/ipl_reset_timer.sv
module ipl_reset_timer #(
  parameter int RST_CYCLES = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam int CW = (RST_CYCLES > 1) ? $clog2(RST_CYCLES) : 1;
  logic [CW-1:0] cnt;

  assign done = busy && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start && !busy) begin
      busy <= 1'b1;
      cnt  <= CW'(RST_CYCLES - 1);
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - 1'b1;
    end
  end

  // R2: the reset window ends by itself and never restarts while running
  assert_done_ends_R2: assert property (@(posedge clk) disable iff (rst)
    done |=> !busy);
endmodule

// File: rtl/ipl_byte_loader.sv
module ipl_byte_loader #(
  parameter int IMG_BYTES = 24,
  parameter int TIMEOUT   = 64,
  parameter int MEM_AW    = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  input  logic              in_err,
  output logic              in_ready,
  output logic              mem_we,
  output logic [MEM_AW-1:0] mem_waddr,
  output logic [7:0]        mem_wdata,
  output logic              ok_o,
  output logic              fail_o
);
  localparam int BCW = $clog2(IMG_BYTES + 1);
  localparam int TCW = $clog2(TIMEOUT + 1);

  logic [BCW-1:0] bcnt;
  logic [TCW-1:0] idle_cnt;
  logic           take, last, tmo;

  assign take = in_ready && in_valid && !in_err;
  assign last = (bcnt == BCW'(IMG_BYTES - 1));
  assign tmo  = in_ready && !in_valid && (idle_cnt == TCW'(TIMEOUT - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      in_ready  <= 1'b0;
      bcnt      <= '0;
      idle_cnt  <= '0;
      mem_we    <= 1'b0;
      mem_waddr <= '0;
      mem_wdata <= '0;
      ok_o      <= 1'b0;
      fail_o    <= 1'b0;
    end else begin
      mem_we <= 1'b0;
      ok_o   <= 1'b0;
      fail_o <= 1'b0;
      if (start && !in_ready) begin
        in_ready <= 1'b1;
        bcnt     <= '0;
        idle_cnt <= '0;
      end else if (in_ready) begin
        if (in_err || tmo) begin
          in_ready <= 1'b0;
          fail_o   <= 1'b1;
        end else if (take) begin
          mem_we    <= 1'b1;
          mem_waddr <= MEM_AW'(bcnt);
          mem_wdata <= in_data;
          bcnt      <= bcnt + 1'b1;
          idle_cnt  <= '0;
          if (last) begin
            in_ready <= 1'b0;
            ok_o     <= 1'b1;
          end
        end else begin
          idle_cnt <= idle_cnt + 1'b1;
        end
      end
    end
  end

  // R3: every accepted clean beat produces one write, inside the image
  assert_take_writes_R3: assert property (@(posedge clk) disable iff (rst)
    (in_ready && in_valid && !in_err) |=> mem_we);
  assert_waddr_range_R3: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (mem_waddr < MEM_AW'(IMG_BYTES)));
  // R5: an error beat is never written and closes the stream
  assert_err_no_write_R5: assert property (@(posedge clk) disable iff (rst)
    (in_ready && in_err) |=> (!mem_we && !in_ready));
  // R6: a failure closes the stream
  assert_fail_closes_R6: assert property (@(posedge clk) disable iff (rst)
    fail_o |-> !in_ready);
endmodule

// File: rtl/ipl_restart_fetch.sv
module ipl_restart_fetch
  import ipl_pkg::*;
#(
  parameter int MEM_AW = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  output logic              mem_re,
  output logic [MEM_AW-1:0] mem_raddr,
  input  logic [7:0]        mem_rdata,
  output logic              start_valid,
  output logic [IA_W-1:0]   start_pc
);
  localparam int ICW = $clog2(SW_BYTES + 1);

  logic [ICW-1:0]          issue_cnt;
  logic                    issuing;
  logic                    cap_v;
  logic [MEM_AW-1:0]       cap_idx;
  logic [IA_W-BYTE_W-1:0]  shift;

  always_ff @(posedge clk) begin
    if (rst) begin
      issuing     <= 1'b0;
      issue_cnt   <= '0;
      mem_re      <= 1'b0;
      mem_raddr   <= '0;
      cap_v       <= 1'b0;
      cap_idx     <= '0;
      shift       <= '0;
      start_valid <= 1'b0;
      start_pc    <= '0;
    end else begin
      mem_re      <= 1'b0;
      start_valid <= 1'b0;
      if (start && !issuing) begin
        issuing   <= 1'b1;
        issue_cnt <= '0;
      end else if (issuing) begin
        mem_re    <= 1'b1;
        mem_raddr <= MEM_AW'(issue_cnt);
        issue_cnt <= issue_cnt + 1'b1;
        if (issue_cnt == ICW'(SW_BYTES - 1)) issuing <= 1'b0;
      end
      cap_v   <= mem_re;
      cap_idx <= mem_raddr;
      if (cap_v) begin
        shift <= {shift[IA_W-2*BYTE_W-1:0], mem_rdata};
        if (cap_idx == MEM_AW'(SW_BYTES - 1)) begin
          start_valid <= 1'b1;
          start_pc    <= {shift, mem_rdata};
        end
      end
    end
  end

  // R7: reads stay inside the status word and the result is a single pulse
  assert_raddr_range_R7: assert property (@(posedge clk) disable iff (rst)
    mem_re |-> (mem_raddr < MEM_AW'(SW_BYTES)));
  assert_pulse_once_R7: assert property (@(posedge clk) disable iff (rst)
    start_valid |=> !start_valid);
endmodule

// File: rtl/ipl_seq.sv
module ipl_seq
  import ipl_pkg::*;
#(
  parameter int RST_CYCLES = 4,
  parameter int IMG_BYTES  = 24,
  parameter int TIMEOUT    = 64,
  parameter int MEM_AW     = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        sel_chan,
  input  logic [3:0]        sel_cu,
  input  logic [3:0]        sel_dev,
  input  logic              load_req,
  input  logic              restart_req,
  input  logic              manual_i,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  input  logic              in_err,
  output logic              in_ready,
  output logic [10:0]       dev_addr,
  output logic              sys_reset_o,
  output logic              mem_we,
  output logic [MEM_AW-1:0] mem_waddr,
  output logic [7:0]        mem_wdata,
  output logic              mem_re,
  output logic [MEM_AW-1:0] mem_raddr,
  input  logic [7:0]        mem_rdata,
  output logic              load_active,
  output logic              load_ok,
  output logic              fail_idle,
  output logic              start_valid,
  output logic [23:0]       start_pc
);
  ipl_state_t state;
  logic load_go, fetch_go, tmr_done, ld_ok, ld_fail, ld_start;

  assign load_go  = load_req && ((state == ST_IDLE) || (state == ST_FAIL));
  assign fetch_go = restart_req && manual_i && !load_req && (state == ST_IDLE);
  assign ld_start = (state == ST_RESET) && tmr_done;

  ipl_reset_timer #(.RST_CYCLES(RST_CYCLES)) u_tmr (
    .clk(clk), .rst(rst), .start(load_go), .busy(sys_reset_o), .done(tmr_done)
  );

  ipl_byte_loader #(.IMG_BYTES(IMG_BYTES), .TIMEOUT(TIMEOUT), .MEM_AW(MEM_AW)) u_ld (
    .clk(clk), .rst(rst), .start(ld_start),
    .in_valid(in_valid), .in_data(in_data), .in_err(in_err), .in_ready(in_ready),
    .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
    .ok_o(ld_ok), .fail_o(ld_fail)
  );

  ipl_restart_fetch #(.MEM_AW(MEM_AW)) u_fch (
    .clk(clk), .rst(rst), .start(fetch_go),
    .mem_re(mem_re), .mem_raddr(mem_raddr), .mem_rdata(mem_rdata),
    .start_valid(start_valid), .start_pc(start_pc)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      dev_addr    <= '0;
      load_active <= 1'b0;
      load_ok     <= 1'b0;
      fail_idle   <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE, ST_FAIL: begin
          if (load_go) begin
            state       <= ST_RESET;
            dev_addr    <= {sel_chan, sel_cu, sel_dev};
            load_active <= 1'b1;
            load_ok     <= 1'b0;
            fail_idle   <= 1'b0;
          end else if (fetch_go) begin
            state <= ST_FETCH;
          end
        end
        ST_RESET: if (tmr_done) state <= ST_LOAD;
        ST_LOAD: begin
          if (ld_ok) begin
            state       <= ST_IDLE;
            load_active <= 1'b0;
            load_ok     <= 1'b1;
          end else if (ld_fail) begin
            state     <= ST_FAIL;
            fail_idle <= 1'b1;
          end
        end
        ST_FETCH: if (start_valid) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R2: nothing is written or accepted while the reset runs
  assert_quiet_reset_R2: assert property (@(posedge clk) disable iff (rst)
    sys_reset_o |-> (!mem_we && !in_ready));
  // R4: success and the load indicator never coexist
  assert_ok_clears_R4: assert property (@(posedge clk) disable iff (rst)
    load_ok |-> !load_active);
  // R5: a failed load keeps its indicator lit
  assert_fail_lit_R5: assert property (@(posedge clk) disable iff (rst)
    fail_idle |-> (load_active && !load_ok));
  // R9: a running load cannot restart the reset window
  assert_no_rerun_R9: assert property (@(posedge clk) disable iff (rst)
    (in_ready && load_req) |=> !sys_reset_o);
endmodule

// File: tb/tb_ipl_seq.sv
module tb_ipl_seq;
  localparam int CLK_P      = 10;
  localparam int RST_CYCLES = 4;
  localparam int IMG_BYTES  = 24;
  localparam int TIMEOUT    = 64;
  localparam int MEM_AW     = 8;

  logic clk = 0, rst = 1;
  logic [2:0] sel_chan = 0;
  logic [3:0] sel_cu = 0, sel_dev = 0;
  logic load_req = 0, restart_req = 0, manual_i = 0;
  logic in_valid = 0, in_err = 0;
  logic [7:0] in_data = 0;
  logic in_ready, sys_reset_o, mem_we, mem_re, load_active, load_ok, fail_idle, start_valid;
  logic [10:0] dev_addr;
  logic [MEM_AW-1:0] mem_waddr, mem_raddr;
  logic [7:0] mem_wdata;
  logic [7:0] mem_rdata = 0;
  logic [23:0] start_pc;

  int checks = 0, errors = 0;
  int we_cnt = 0, re_cnt = 0, rst_cnt = 0, sv_cnt = 0;
  logic [7:0] mem [0:(1<<MEM_AW)-1];
  logic [7:0] img [0:IMG_BYTES-1];
  bit finished = 0;

  always #(CLK_P/2) clk = ~clk;

  ipl_seq #(.RST_CYCLES(RST_CYCLES), .IMG_BYTES(IMG_BYTES), .TIMEOUT(TIMEOUT),
            .MEM_AW(MEM_AW)) dut (
    .clk(clk), .rst(rst), .sel_chan(sel_chan), .sel_cu(sel_cu), .sel_dev(sel_dev),
    .load_req(load_req), .restart_req(restart_req), .manual_i(manual_i),
    .in_valid(in_valid), .in_data(in_data), .in_err(in_err), .in_ready(in_ready),
    .dev_addr(dev_addr), .sys_reset_o(sys_reset_o),
    .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
    .mem_re(mem_re), .mem_raddr(mem_raddr), .mem_rdata(mem_rdata),
    .load_active(load_active), .load_ok(load_ok), .fail_idle(fail_idle),
    .start_valid(start_valid), .start_pc(start_pc));

  always @(posedge clk) begin
    if (mem_we) begin mem[mem_waddr] <= mem_wdata; we_cnt <= we_cnt + 1; end
    if (mem_re) begin mem_rdata <= mem[mem_raddr]; re_cnt <= re_cnt + 1; end
    if (sys_reset_o) rst_cnt <= rst_cnt + 1;
    if (start_valid) sv_cnt <= sv_cnt + 1;
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [10:0] exp_dev(input logic [2:0] c, input logic [3:0] u,
                                          input logic [3:0] d);
    return {c, u, d};
  endfunction

  task automatic start_load(input logic [2:0] c, input logic [3:0] u, input logic [3:0] d);
    int r0;
    @(negedge clk);
    sel_chan = c; sel_cu = u; sel_dev = d; load_req = 1;
    r0 = rst_cnt;
    @(posedge clk); @(negedge clk);
    load_req = 0;
    chk(load_active && sys_reset_o && !load_ok && !fail_idle, "R4", load_active, 1);
    chk(dev_addr == exp_dev(c, u, d), "R1", dev_addr, exp_dev(c, u, d));
    for (int i = 0; i < 20 && !in_ready; i++) @(negedge clk);
    chk(rst_cnt - r0 == RST_CYCLES && !sys_reset_o && in_ready, "R2", rst_cnt - r0, RST_CYCLES);
  endtask

  task automatic send_byte(input logic [7:0] b, input int gap);
    repeat (gap) @(negedge clk);
    in_valid = 1; in_data = b;
    @(posedge clk); @(negedge clk);
    in_valid = 0;
  endtask

  task automatic good_load(input bit poke);
    logic [2:0] c; logic [3:0] u, d; int w0; bit mok;
    c = 3'($urandom); u = 4'($urandom); d = 4'($urandom);
    for (int k = 0; k < IMG_BYTES; k++) img[k] = 8'($urandom);
    start_load(c, u, d);
    w0 = we_cnt;
    for (int k = 0; k < IMG_BYTES; k++) begin
      if (poke && k == 9) begin
        load_req = 1; restart_req = 1; manual_i = 1;
        @(negedge clk);
        load_req = 0; restart_req = 0; manual_i = 0;
      end
      send_byte(img[k], int'($urandom_range(0, 3)));
    end
    chk(!in_ready, "R3", in_ready, 0);
    @(posedge clk); @(negedge clk);
    chk(load_ok && !load_active, "R4", {load_ok, load_active}, 2'b10);
    chk(we_cnt - w0 == IMG_BYTES, "R3", we_cnt - w0, IMG_BYTES);
    mok = 1;
    for (int k = 0; k < IMG_BYTES; k++) if (mem[k] !== img[k]) mok = 0;
    chk(mok, poke ? "R9" : "R3", mok, 1);
    mok = 1;
    for (int k = IMG_BYTES; k < IMG_BYTES + 16; k++) if (mem[k] !== 8'hEE) mok = 0;
    chk(mok, "R3", mok, 1);
    chk(dev_addr == exp_dev(c, u, d), "R1", dev_addr, exp_dev(c, u, d));
  endtask

  initial begin
    void'($urandom(32'd4242));
    for (int a = 0; a < (1<<MEM_AW); a++) mem[a] = 8'hEE;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    chk(!load_active && !load_ok && !fail_idle && !sys_reset_o && !in_ready &&
        !mem_we && !mem_re && !start_valid, "R10", load_active, 0);

    // main function under several random images and selector settings
    good_load(0);
    good_load(1);   // R9: requests in mid-load ignored
    good_load(0);

    begin : restart_ok
      int r0, s0, n; logic [23:0] e;
      e = {img[5], img[6], img[7]};
      r0 = re_cnt; s0 = sv_cnt;
      @(negedge clk); restart_req = 1; manual_i = 1;
      @(negedge clk); restart_req = 0;
      n = 0;
      while (!start_valid && n < 30) begin @(negedge clk); n++; end
      chk(start_valid && start_pc == e, "R7", start_pc, e);
      chk(re_cnt - r0 == 8, "R7", re_cnt - r0, 8);
      @(negedge clk);
      chk(sv_cnt - s0 == 1, "R7", sv_cnt - s0, 1);
    end

    begin : restart_ignored
      int r0, s0;
      r0 = re_cnt; s0 = sv_cnt;
      @(negedge clk); restart_req = 1; manual_i = 0;
      @(negedge clk); restart_req = 0;
      repeat (20) @(negedge clk);
      chk(re_cnt == r0 && sv_cnt == s0, "R8", re_cnt - r0, 0);
    end

    begin : err_load
      int w0; logic [7:0] keep;
      keep = mem[10];
      start_load(3'd1, 4'h8, 4'h3);
      w0 = we_cnt;
      for (int k = 0; k < 10; k++) send_byte(8'($urandom), 0);
      in_valid = 1; in_err = 1; in_data = 8'h5A;
      @(posedge clk); @(negedge clk);
      in_valid = 0; in_err = 0;
      @(posedge clk); @(negedge clk);
      chk(fail_idle && load_active && !load_ok && !in_ready, "R5", {fail_idle, load_active}, 2'b11);
      repeat (5) @(negedge clk);
      chk(we_cnt - w0 == 10 && mem[10] == keep, "R5", we_cnt - w0, 10);
    end

    begin : tmo_load
      start_load(3'd0, 4'h0, 4'hC);
      repeat (TIMEOUT - 1) @(posedge clk);
      @(negedge clk);
      chk(!fail_idle && in_ready, "R6", fail_idle, 0);
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(fail_idle && load_active && !in_ready, "R6", {fail_idle, load_active}, 2'b11);
    end

    good_load(0);   // R4: a new load clears the failure
    chk(!fail_idle, "R4", fail_idle, 0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule